// File: doc/BRIEF.md
# Watchdog and Reset Supervisor

This block drives one system reset line from two causes. The first is a low-supply condition: a synchronous supply-good flag comes from an external comparator, and reset is held while the flag is low and for a fixed hold period after it recovers. The second is a watchdog. A host restarts the watchdog by pulling its chip-select line low. If that line stays at one level, high or low, for longer than the selected timeout, the block issues a reset pulse of fixed length.

A 2-bit code, normally held in a status register, selects one of three timeouts or turns the watchdog off. Every duration is a count of clock ticks set by a parameter. A build parameter selects whether the reset output is active-low or active-high; the logic behind the output is the same in both builds.

The chip-select line passes through a two-stage synchronizer. A low pulse shorter than a programmable minimum width does not count as a restart. While the low-supply reset is active, the watchdog counter is held at zero. The counter also returns to zero whenever the timeout code changes.

Top module: `rstsup_top`

## Requirements
- R1: When `supply_ok_i` is sampled low on a clock edge, reset is active from that edge on. After `rst_ni` is released, reset stays active until the supply flag has recovered.
- R2: The low-supply reset ends after `supply_ok_i` has been sampled high on HOLD_TICKS consecutive edges. A single low sample restarts the hold period.
- R3: A valid chip-select restart returns the watchdog count to zero. Restarts spaced closer than the selected timeout keep reset inactive indefinitely.
- R4: The timeout code maps 2'b10 to SHORT_TICKS, 2'b01 to MID_TICKS and 2'b00 to LONG_TICKS. After the last restart, reset asserts once the selected number of ticks has passed, whether chip-select is held high or held low.
- R5: Code 2'b11 disables the watchdog, so no watchdog reset is ever produced while that code is held.
- R6: A watchdog expiry holds reset active for PULSE_TICKS cycles and then releases it.
- R7: A chip-select low pulse counts as a restart only when it is sampled low after synchronization on at least MIN_LOW_TICKS consecutive edges. A narrower pulse has no effect on the timeout.
- R8: A change of the timeout code returns the watchdog count to zero, so the new timeout is measured from the change.
- R9: While the low-supply reset is active, the watchdog count is held at zero. Counting starts on the cycle after the hold period ends.
- R10: With ACTIVE_LOW=1 the output is low while reset is active. With ACTIVE_LOW=0 the output is high while reset is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| supply_ok_i | input | 1 | Synchronous supply-good flag, high when the supply is above its trip point |
| cs_ni | input | 1 | Chip-select line; its low pulses restart the watchdog |
| wd_code_i | input | 2 | Timeout select: 00 long, 01 mid, 10 short, 11 off |
| sys_rst_o | output | 1 | System reset, with polarity set by ACTIVE_LOW |

## Verification
Chip-select is driven in four patterns. Regular full-width pulses show that restarts keep reset away. A line held high and a line held low each show that expiry occurs at the selected timeout. A train of narrow pulses shows that the width filter throws away short glitches, because the expiry time does not move. The supply flag is tested with a long outage and with a one-cycle dropout, which separate the assert path from the hold-period release. An outage longer than the timeout shows that the watchdog count is frozen during low-supply reset. A code change halfway through a count shows the restart on a new code. Two instances, one of each polarity, are compared at every check.

// File: rtl/rstsup_pkg.sv
package rstsup_pkg;

  typedef enum logic [1:0] {
    WD_LONG  = 2'b00,
    WD_MID   = 2'b01,
    WD_SHORT = 2'b10,
    WD_OFF   = 2'b11
  } wd_code_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/rstsup_supply_hold.sv
module rstsup_supply_hold #(
  parameter int unsigned HOLD_TICKS = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  output logic por_o
);
  localparam int unsigned CW = $clog2(HOLD_TICKS + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      por_o <= 1'b1;
      cnt_q <= '0;
    end else if (!supply_ok_i) begin
      por_o <= 1'b1;
      cnt_q <= '0;
    end else if (por_o) begin
      if (cnt_q == CW'(HOLD_TICKS - 1)) begin
        por_o <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/rstsup_cs_filter.sv
module rstsup_cs_filter #(
  parameter int unsigned MIN_LOW_TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  output logic cs_sync_o,
  output logic kick_o
);
  localparam int unsigned RW = $clog2(MIN_LOW_TICKS + 1);

  logic          meta_q;
  logic          sync_q;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      run_q  <= '0;
    end else begin
      meta_q <= cs_ni;
      sync_q <= meta_q;
      if (sync_q) begin
        run_q <= '0;
      end else if (run_q != RW'(MIN_LOW_TICKS)) begin
        run_q <= run_q + RW'(1);
      end
    end
  end

  // One restart per low run, on the sample that reaches the minimum width.
  assign kick_o    = !sync_q && (run_q == RW'(MIN_LOW_TICKS - 1));
  assign cs_sync_o = sync_q;
endmodule

// File: rtl/rstsup_watchdog.sv
module rstsup_watchdog
  import rstsup_pkg::*;
#(
  parameter int unsigned LONG_TICKS  = 1400,
  parameter int unsigned MID_TICKS   = 600,
  parameter int unsigned SHORT_TICKS = 200,
  parameter int unsigned CW          = $clog2(max3(LONG_TICKS, MID_TICKS, SHORT_TICKS) + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          por_i,
  input  logic          hold_i,
  input  logic          kick_i,
  input  logic [1:0]    code_i,
  output logic          expire_o,
  output logic [CW-1:0] cnt_o
);
  logic [1:0]    code_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;
  logic          clear;

  always_comb begin
    unique case (wd_code_e'(code_i))
      WD_LONG:  limit = CW'(LONG_TICKS - 1);
      WD_MID:   limit = CW'(MID_TICKS - 1);
      WD_SHORT: limit = CW'(SHORT_TICKS - 1);
      default:  limit = '0;
    endcase
  end

  assign clear = por_i || hold_i || kick_i || (code_i == WD_OFF) || (code_i != code_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= WD_OFF;
      cnt_q  <= '0;
    end else begin
      code_q <= code_i;
      if (clear || (cnt_q == limit)) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign expire_o = !clear && (cnt_q == limit);
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/rstsup_stretch.sv
module rstsup_stretch #(
  parameter int unsigned PULSE_TICKS = 300
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_i,
  input  logic expire_i,
  output logic hold_o
);
  localparam int unsigned PW = $clog2(PULSE_TICKS + 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_o <= 1'b0;
      cnt_q  <= '0;
    end else if (por_i) begin
      hold_o <= 1'b0;
      cnt_q  <= '0;
    end else if (hold_o) begin
      if (cnt_q == PW'(PULSE_TICKS - 1)) begin
        hold_o <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + PW'(1);
      end
    end else if (expire_i) begin
      hold_o <= 1'b1;
      cnt_q  <= '0;
    end
  end
endmodule

// File: rtl/rstsup_top.sv
module rstsup_top
  import rstsup_pkg::*;
#(
  parameter bit          ACTIVE_LOW    = 1'b1,
  parameter int unsigned HOLD_TICKS    = 200,
  parameter int unsigned LONG_TICKS    = 1400,
  parameter int unsigned MID_TICKS     = 600,
  parameter int unsigned SHORT_TICKS   = 200,
  parameter int unsigned PULSE_TICKS   = 300,
  parameter int unsigned MIN_LOW_TICKS = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       supply_ok_i,
  input  logic       cs_ni,
  input  logic [1:0] wd_code_i,
  output logic       sys_rst_o
);
  localparam int unsigned WD_W = $clog2(max3(LONG_TICKS, MID_TICKS, SHORT_TICKS) + 1);

  logic            por_w;
  logic            hold_w;
  logic            kick_w;
  logic            cs_sync_w;
  logic            expire_w;
  logic [WD_W-1:0] wd_cnt_w;
  logic            active_w;

  rstsup_supply_hold #(.HOLD_TICKS(HOLD_TICKS)) u_supply (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .supply_ok_i (supply_ok_i),
    .por_o       (por_w)
  );

  rstsup_cs_filter #(.MIN_LOW_TICKS(MIN_LOW_TICKS)) u_csflt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_ni     (cs_ni),
    .cs_sync_o (cs_sync_w),
    .kick_o    (kick_w)
  );

  rstsup_watchdog #(
    .LONG_TICKS  (LONG_TICKS),
    .MID_TICKS   (MID_TICKS),
    .SHORT_TICKS (SHORT_TICKS),
    .CW          (WD_W)
  ) u_wdog (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .por_i    (por_w),
    .hold_i   (hold_w),
    .kick_i   (kick_w),
    .code_i   (wd_code_i),
    .expire_o (expire_w),
    .cnt_o    (wd_cnt_w)
  );

  rstsup_stretch #(.PULSE_TICKS(PULSE_TICKS)) u_stretch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .por_i    (por_w),
    .expire_i (expire_w),
    .hold_o   (hold_w)
  );

  assign active_w = por_w || hold_w;

  generate
    if (ACTIVE_LOW) begin : g_out_low
      assign sys_rst_o = ~active_w;
    end else begin : g_out_high
      assign sys_rst_o = active_w;
    end
  endgenerate
endmodule

// File: rtl/rstsup_checker.sv
module rstsup_checker #(
  parameter bit          ACTIVE_LOW = 1'b1,
  parameter int unsigned CW         = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          supply_ok_i,
  input logic [1:0]    wd_code_i,
  input logic          sys_rst_o,
  input logic          por_i,
  input logic          hold_i,
  input logic          kick_i,
  input logic          cs_sync_i,
  input logic          expire_i,
  input logic [CW-1:0] wd_cnt_i
);
  logic rst_on;
  assign rst_on = ACTIVE_LOW ? !sys_rst_o : sys_rst_o;

  p_supply_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> rst_on);

  p_release_after_ok_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(por_i) |-> $past(supply_ok_i));

  p_kick_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kick_i && !por_i) |=> (wd_cnt_i == '0));

  p_expire_resets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> rst_on);

  p_off_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wd_code_i == 2'b11) && ($past(wd_code_i) == 2'b11)) |-> !$rose(hold_i));

  p_pulse_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_i) |=> (hold_i || por_i));

  p_wide_low_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |-> (!cs_sync_i && !$past(cs_sync_i)));

  p_code_change_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd_code_i != $past(wd_code_i)) |=> (wd_cnt_i == '0));

  p_por_freeze_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> (wd_cnt_i == '0));
endmodule

bind rstsup_top rstsup_checker #(.ACTIVE_LOW(ACTIVE_LOW), .CW(WD_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .supply_ok_i (supply_ok_i),
  .wd_code_i   (wd_code_i),
  .sys_rst_o   (sys_rst_o),
  .por_i       (por_w),
  .hold_i      (hold_w),
  .kick_i      (kick_w),
  .cs_sync_i   (cs_sync_w),
  .expire_i    (expire_w),
  .wd_cnt_i    (wd_cnt_w)
);

// File: tb/rstsup_top_tb_top.sv
`timescale 1ns/1ps
module rstsup_top_tb_top;
  localparam int HOLD  = 200;
  localparam int LONG  = 1400;
  localparam int MID   = 600;
  localparam int SHORT = 200;
  localparam int PULSE = 300;
  localparam int MINW  = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       supply_ok = 1'b0;
  logic       cs_n = 1'b1;
  logic [1:0] code = 2'b11;
  logic       rst_lo;
  logic       rst_hi;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  rstsup_top #(.ACTIVE_LOW(1'b1), .HOLD_TICKS(HOLD), .LONG_TICKS(LONG), .MID_TICKS(MID),
               .SHORT_TICKS(SHORT), .PULSE_TICKS(PULSE), .MIN_LOW_TICKS(MINW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .supply_ok_i(supply_ok), .cs_ni(cs_n),
    .wd_code_i(code), .sys_rst_o(rst_lo));

  rstsup_top #(.ACTIVE_LOW(1'b0), .HOLD_TICKS(HOLD), .LONG_TICKS(LONG), .MID_TICKS(MID),
               .SHORT_TICKS(SHORT), .PULSE_TICKS(PULSE), .MIN_LOW_TICKS(MINW)) dut_hi_i (
    .clk_i(clk), .rst_ni(rst_ni), .supply_ok_i(supply_ok), .cs_ni(cs_n),
    .wd_code_i(code), .sys_rst_o(rst_hi));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Every check also compares both polarities (R10).
  task automatic chk(input bit exp_on, input string tag);
    checks++;
    if (rst_lo !== ~exp_on || rst_hi !== exp_on) begin
      errors++;
      $display("FAIL %s R10: low-build=%b high-build=%b expected low-build=%b high-build=%b",
               tag, rst_lo, rst_hi, ~exp_on, exp_on);
    end
  endtask

  task automatic power_up(input logic [1:0] c);
    rst_ni = 1'b0; supply_ok = 1'b0; cs_n = 1'b1; code = c;
    step(3);
    rst_ni = 1'b1;
    step(2);
    supply_ok = 1'b1;
    step(HOLD + 4);
  endtask

  task automatic kick();
    cs_n = 1'b0;
    step(MINW + 4);
    cs_n = 1'b1;
  endtask

  task automatic t_reset_and_hold();
    rst_ni = 1'b0; supply_ok = 1'b0; code = 2'b11;
    step(3);
    chk(1'b1, "R1 in reset");
    rst_ni = 1'b1;
    step(5);
    chk(1'b1, "R1 supply low after reset");
    supply_ok = 1'b1;
    step(HOLD - 4);
    chk(1'b1, "R2 before hold ends");
    step(8);
    chk(1'b0, "R2 after hold ends");
  endtask

  task automatic t_dropout();
    supply_ok = 1'b0;
    step(1);
    supply_ok = 1'b1;
    chk(1'b1, "R1 single low sample");
    step(HOLD - 4);
    chk(1'b1, "R2 hold restarted");
    step(8);
    chk(1'b0, "R2 released after dropout");
  endtask

  task automatic t_disabled();
    power_up(2'b11);
    step(1500);
    chk(1'b0, "R5 off mid");
    step(1500);
    chk(1'b0, "R5 off end");
  endtask

  task automatic t_timeout(input logic [1:0] c, input int lim, input string tag);
    power_up(c);
    kick();
    step(lim - 10);
    chk(1'b0, {"R4 before timeout ", tag});
    step(12);
    chk(1'b1, {"R4 after timeout ", tag});
    step(PULSE - 10);
    chk(1'b1, {"R6 pulse held ", tag});
    step(12);
    chk(1'b0, {"R6 pulse released ", tag});
  endtask

  task automatic t_kicks();
    power_up(2'b10);
    for (int i = 0; i < 8; i++) begin
      kick();
      step(150 - (MINW + 4));
      chk(1'b0, "R3 regular restarts");
    end
  endtask

  task automatic t_low_held();
    power_up(2'b10);
    cs_n = 1'b0;
    step(SHORT - 2);
    chk(1'b0, "R4 cs low before timeout");
    step(12);
    chk(1'b1, "R4 cs held low expires");
    cs_n = 1'b1;
  endtask

  task automatic t_narrow();
    power_up(2'b10);
    kick();
    for (int i = 0; i < 4; i++) begin
      step(40 - (MINW - 1));
      cs_n = 1'b0;
      step(MINW - 1);
      cs_n = 1'b1;
    end
    step(SHORT - 160 - 20);
    chk(1'b0, "R7 before timeout");
    step(22);
    chk(1'b1, "R7 narrow pulses ignored");
  endtask

  task automatic t_code_change();
    power_up(2'b01);
    kick();
    step(392);
    code = 2'b00;
    step(400);
    chk(1'b0, "R8 old timeout passed");
    step(990);
    chk(1'b0, "R8 before new timeout");
    step(22);
    chk(1'b1, "R8 new timeout from change");
  endtask

  task automatic t_por_freeze();
    rst_ni = 1'b0; supply_ok = 1'b0; cs_n = 1'b1; code = 2'b10;
    step(3);
    rst_ni = 1'b1;
    step(600);
    chk(1'b1, "R9 long outage");
    supply_ok = 1'b1;
    step(HOLD + 4);
    chk(1'b0, "R9 released");
    step(SHORT - 10);
    chk(1'b0, "R9 counter frozen during outage");
    step(12);
    chk(1'b1, "R9 counts from release");
  endtask

  initial begin
    step(100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset_and_hold();
    t_dropout();
    t_disabled();
    t_timeout(2'b10, SHORT, "short");
    t_timeout(2'b01, MID, "mid");
    t_timeout(2'b00, LONG, "long");
    t_kicks();
    t_low_held();
    t_narrow();
    t_code_change();
    t_por_freeze();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule